// File: doc/BRIEF.md
# Branch and Call Next-Address Sequencer

This block decides where a small 16-bit-instruction processor fetches next. It owns the program counter register. Each cycle in which an instruction is presented as valid, it inspects the instruction's control-transfer fields and tests a 3-bit condition against the N/Z/C/V flags. It then forms either a PC-relative target or a register target, or it falls through to the next sequential address. Calls request a link-register write carrying the address of the instruction after the call.

Delayed transfers let exactly one further instruction, the delay slot, execute before control moves. The target is parked in an internal register while the slot instruction runs. Any transfer that appears in a slot is treated as a no-op. Addresses count bytes, and every instruction is 2 bytes. The rest of the core supplies the value of the selected source register and the current link value. It performs the link write when asked.

Top module: `nextpc_seq`

## Requirements
- R1: While reset is asserted and on the first edge after it, `pc_o` is 0 and no delayed transfer is pending.
- R2: Condition field c selects: 0 Z, 1 not Z, 2 N xor V, 3 Z or (N xor V), 4 C, 5 N, 6 V, 7 always. Flags are `flags_i` = {N,Z,C,V} (bit 3 is N, bit 0 is V).
- R3: Relative branch: `instr_i[15:12]`=1110, condition in [2:0], delay select in [3], signed byte offset in [11:4]. If taken, the next PC is the branch's own address plus the offset. If not taken, it is PC+2.
- R4: Register branch: `instr_i[15:8]`=0xF0 with [3]=0, condition in [2:0]. If taken, the next PC is `src_i` with bit 0 cleared.
- R5: A taken delayed transfer (relative branch with [3]=1, or `instr_i[15:8]`=0xF1 with [3]=0) moves to PC+2 first. After the next valid instruction, it moves to the target. A not-taken delayed branch leaves nothing pending.
- R6: An instruction executed in a delay slot never transfers control and never writes the link. The PC after it is the pending target.
- R7: Long call: `instr_i[15:11]`=11111. The next PC is PC plus the signed 11-bit offset in [10:0]. `lr_we_o`=1 with `lr_wdata_o`=PC+2.
- R8: Delayed call: `instr_i[15:8]`=0xF5 with a signed offset in [7:0]. The link becomes PC+2, which is the slot address. The PC moves to PC+2, then to PC+offset after the slot.
- R9: Register call: `instr_i[15:8]`=0xF6. With [3:0]=0 it always jumps to `src_i` with bit 0 cleared and writes the link with PC+2. With [3]=1 it does so only when condition [2:0] holds; otherwise it writes no link and goes to PC+2.
- R10: Return (`instr_i`=0xF400) makes the next PC equal to `link_i`.
- R11: While `instr_valid_i` is 0, the PC and any pending target are held and `lr_we_o` is 0.
- R12: Any other encoding, including 0xF0/0xF1 with [3]=1 and 0xF7xx, advances the PC by 2 without a link write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | The instruction at `pc_o` executes this cycle |
| instr_i | input | 16 | Instruction word fetched from `pc_o` |
| flags_i | input | 4 | {N,Z,C,V} condition flags |
| src_i | input | 16 | Value of the instruction's source register |
| link_i | input | 16 | Current link register value |
| pc_o | output | 16 | Address of the instruction to fetch and execute |
| lr_we_o | output | 1 | Link register write enable (combinational) |
| lr_wdata_o | output | 16 | Link register write data |

## Verification
A wrong pending-slot flag shows up at `pc_o` within two valid instructions. Either a delayed target is never reached, or a transfer sitting in a slot is obeyed. A corrupted held target surfaces on the first valid cycle after the slot as a wrong `pc_o`. A flipped condition decode shows as a PC+2 where a target was due, or the reverse, on the very next edge. Link errors are visible in the same cycle as the call, on `lr_we_o` and `lr_wdata_o`.

// File: rtl/flow_pkg.sv
package flow_pkg;
   typedef enum logic [2:0] {
      CC_EQ = 3'd0, CC_NE = 3'd1, CC_LT = 3'd2, CC_LE = 3'd3,
      CC_LO = 3'd4, CC_MI = 3'd5, CC_VS = 3'd6, CC_AL = 3'd7
   } cond_e;

   typedef enum logic [2:0] {
      TGT_SEQ, TGT_REL_MID, TGT_REL_LOW, TGT_REL_LONG, TGT_REG, TGT_LINK
   } tgt_e;

   typedef struct packed {
      logic  is_xfer;
      logic  guarded;
      logic  delayed;
      logic  links;
      tgt_e  tsel;
      cond_e cc;
   } xfer_t;

   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_C = 1;
   localparam int FLAG_V = 0;
endpackage

// File: rtl/cond_eval.sv
module cond_eval
   import flow_pkg::*;
(
   input  logic [3:0] flags_i,
   input  cond_e      cc_i,
   output logic       pass_o
);
   logic n, z, c, v, lt;
   assign n  = flags_i[FLAG_N];
   assign z  = flags_i[FLAG_Z];
   assign c  = flags_i[FLAG_C];
   assign v  = flags_i[FLAG_V];
   assign lt = n ^ v;

   always_comb begin
      unique case (cc_i)
         CC_EQ:   pass_o = z;
         CC_NE:   pass_o = ~z;
         CC_LT:   pass_o = lt;
         CC_LE:   pass_o = z | lt;
         CC_LO:   pass_o = c;
         CC_MI:   pass_o = n;
         CC_VS:   pass_o = v;
         default: pass_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/xfer_decode.sv
module xfer_decode
   import flow_pkg::*;
(
   input  logic [15:0] instr_i,
   output xfer_t       xf_o
);
   logic [7:0] hi;
   assign hi = instr_i[15:8];

   always_comb begin
      xf_o = '{is_xfer: 1'b0, guarded: 1'b0, delayed: 1'b0, links: 1'b0,
               tsel: TGT_SEQ, cc: CC_AL};
      if (instr_i[15:12] == 4'hE) begin
         xf_o.is_xfer = 1'b1;
         xf_o.guarded = 1'b1;
         xf_o.delayed = instr_i[3];
         xf_o.tsel    = TGT_REL_MID;
         xf_o.cc      = cond_e'(instr_i[2:0]);
      end else if (instr_i[15:11] == 5'b11111) begin
         xf_o.is_xfer = 1'b1;
         xf_o.links   = 1'b1;
         xf_o.tsel    = TGT_REL_LONG;
      end else if ((hi == 8'hF0 || hi == 8'hF1) && !instr_i[3]) begin
         xf_o.is_xfer = 1'b1;
         xf_o.guarded = 1'b1;
         xf_o.delayed = hi[0];
         xf_o.tsel    = TGT_REG;
         xf_o.cc      = cond_e'(instr_i[2:0]);
      end else if (hi == 8'hF4 && instr_i[7:0] == 8'h00) begin
         xf_o.is_xfer = 1'b1;
         xf_o.tsel    = TGT_LINK;
      end else if (hi == 8'hF5) begin
         xf_o.is_xfer = 1'b1;
         xf_o.delayed = 1'b1;
         xf_o.links   = 1'b1;
         xf_o.tsel    = TGT_REL_LOW;
      end else if (hi == 8'hF6 && (instr_i[3] || instr_i[2:0] == 3'd0)) begin
         xf_o.is_xfer = 1'b1;
         xf_o.links   = 1'b1;
         xf_o.guarded = instr_i[3];
         xf_o.tsel    = TGT_REG;
         xf_o.cc      = cond_e'(instr_i[2:0]);
      end
   end
endmodule

// File: rtl/target_gen.sv
module target_gen
   import flow_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int INSTR_BYTES = 2
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] src_i,
   input  logic [ADDR_W-1:0] link_i,
   input  logic [7:0]        off_mid_i,
   input  logic [7:0]        off_low_i,
   input  logic [10:0]       off_long_i,
   input  tgt_e              tsel_i,
   output logic [ADDR_W-1:0] seq_o,
   output logic [ADDR_W-1:0] target_o
);
   localparam int ALIGN = $clog2(INSTR_BYTES);

   logic [ADDR_W-1:0] reg_tgt;

   assign seq_o = pc_i + ADDR_W'(INSTR_BYTES);

   generate
      if (ALIGN > 0) begin : g_align
         assign reg_tgt = {src_i[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};
      end else begin : g_noalign
         assign reg_tgt = src_i;
      end
   endgenerate

   always_comb begin
      unique case (tsel_i)
         TGT_REL_MID:  target_o = pc_i + {{(ADDR_W-8){off_mid_i[7]}}, off_mid_i};
         TGT_REL_LOW:  target_o = pc_i + {{(ADDR_W-8){off_low_i[7]}}, off_low_i};
         TGT_REL_LONG: target_o = pc_i + {{(ADDR_W-11){off_long_i[10]}}, off_long_i};
         TGT_REG:      target_o = reg_tgt;
         TGT_LINK:     target_o = link_i;
         default:      target_o = seq_o;
      endcase
   end
endmodule

// File: rtl/nextpc_seq.sv
module nextpc_seq
   import flow_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int                INSTR_BYTES = 2,
   parameter logic [ADDR_W-1:0] RESET_PC    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid_i,
   input  logic [15:0]       instr_i,
   input  logic [3:0]        flags_i,
   input  logic [ADDR_W-1:0] src_i,
   input  logic [ADDR_W-1:0] link_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic              lr_we_o,
   output logic [ADDR_W-1:0] lr_wdata_o
);
   initial begin
      assert (ADDR_W >= 12) else $error("ADDR_W must hold an 11-bit offset");
      assert (INSTR_BYTES >= 1 && (INSTR_BYTES & (INSTR_BYTES - 1)) == 0)
         else $error("INSTR_BYTES must be a power of two");
   end

   xfer_t             xf;
   logic              pass;
   logic [ADDR_W-1:0] seq, target;
   logic [ADDR_W-1:0] pc_q, tgt_q;
   logic              slot_q;
   logic              go;

   xfer_decode u_dec (.instr_i(instr_i), .xf_o(xf));

   cond_eval u_cond (.flags_i(flags_i), .cc_i(xf.cc), .pass_o(pass));

   target_gen #(.ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_tgt (
      .pc_i       (pc_q),
      .src_i      (src_i),
      .link_i     (link_i),
      .off_mid_i  (instr_i[11:4]),
      .off_low_i  (instr_i[7:0]),
      .off_long_i (instr_i[10:0]),
      .tsel_i     (xf.tsel),
      .seq_o      (seq),
      .target_o   (target)
   );

   assign go = instr_valid_i && !slot_q && xf.is_xfer && (!xf.guarded || pass);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= RESET_PC;
         tgt_q  <= '0;
         slot_q <= 1'b0;
      end else if (instr_valid_i) begin
         if (slot_q) begin
            pc_q   <= tgt_q;
            slot_q <= 1'b0;
         end else if (go && xf.delayed) begin
            pc_q   <= seq;
            tgt_q  <= target;
            slot_q <= 1'b1;
         end else if (go) begin
            pc_q <= target;
         end else begin
            pc_q <= seq;
         end
      end
   end

   assign pc_o       = pc_q;
   assign lr_we_o    = go && xf.links;
   assign lr_wdata_o = seq;
endmodule

// File: rtl/nextpc_seq_chk.sv
module nextpc_seq_chk #(
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid_i,
   input logic [ADDR_W-1:0] pc_o,
   input logic              lr_we_o,
   input logic              slot_q,
   input logic [ADDR_W-1:0] tgt_q
);
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (pc_o == RESET_PC) && !slot_q);

   a_r11_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid_i |=> $stable(pc_o) && $stable(slot_q));

   a_r11_no_link: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid_i |-> !lr_we_o);

   a_r6_slot_no_link: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q |-> !lr_we_o);

   a_r6_slot_target: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid_i && slot_q) |=> (pc_o == $past(tgt_q)) && !slot_q);
endmodule

bind nextpc_seq nextpc_seq_chk #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .instr_valid_i (instr_valid_i),
   .pc_o          (pc_o),
   .lr_we_o       (lr_we_o),
   .slot_q        (slot_q),
   .tgt_q         (tgt_q)
);

// File: tb/nextpc_seq_tb.sv
`timescale 1ns/1ps
module nextpc_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld = 1'b0;
   logic [15:0] ins = 16'h0000;
   logic [3:0]  flg = 4'h0;
   logic [15:0] src = 16'h0000;
   logic [15:0] lnk = 16'h0000;
   logic [15:0] pc;
   logic        we;
   logic [15:0] wd;

   int checks = 0;
   int fails  = 0;
   logic        got_we;
   logic [15:0] got_wd, got_pc;

   always #2 clk = ~clk;

   nextpc_seq u_dut (
      .clk(clk), .rst_n(rst_n), .instr_valid_i(vld), .instr_i(ins),
      .flags_i(flg), .src_i(src), .link_i(lnk),
      .pc_o(pc), .lr_we_o(we), .lr_wdata_o(wd)
   );

   task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                      input logic [15:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [15:0] i, input logic [3:0] f,
                       input logic [15:0] s, input logic [15:0] l, input bit v);
      @(negedge clk);
      ins = i; flg = f; src = s; lnk = l; vld = v;
      #1;
      got_we = we;
      got_wd = wd;
      @(posedge clk);
      #1;
      got_pc = pc;
   endtask

   function automatic bit cond_ok(input logic [2:0] c, input logic [3:0] f);
      logic n, z, cy, v;
      {n, z, cy, v} = f;
      case (c)
         3'd0: return z;
         3'd1: return !z;
         3'd2: return n != v;
         3'd3: return z || (n != v);
         3'd4: return cy;
         3'd5: return n;
         3'd6: return v;
         default: return 1'b1;
      endcase
   endfunction

   localparam logic [15:0] PLAIN = 16'hC012;

   task automatic t_reset();
      repeat (3) @(posedge clk);
      #1;
      chk(pc == 16'h0, "R1 pc in reset", pc, 16'h0);
      @(negedge clk);
      rst_n = 1'b1;
      step(PLAIN, 4'h0, 16'h0, 16'h0, 1'b0);
      chk(got_pc == 16'h0, "R1 pc after reset", got_pc, 16'h0);
      step(PLAIN, 4'h0, 16'h0, 16'h0, 1'b1);
      chk(got_pc == 16'h2, "R1 no pending after reset", got_pc, 16'h2);
   endtask

   task automatic t_cond();
      for (int c = 0; c < 8; c++) begin
         for (int f = 0; f < 16; f++) begin
            logic [15:0] base, exp;
            base = pc;
            exp = cond_ok(3'(c), 4'(f)) ? base + 16'h8 : base + 16'h2;
            step({4'hE, 8'h08, 1'b0, 3'(c)}, 4'(f), 16'h0, 16'h0, 1'b1);
            chk(got_pc == exp, $sformatf("R2 cc=%0d flags=%h", c, f), got_pc, exp);
         end
      end
   endtask

   task automatic t_rel();
      logic [15:0] base;
      base = pc;
      step({4'hE, 8'hFA, 1'b0, 3'd7}, 4'h0, 16'h0, 16'h0, 1'b1);
      chk(got_pc == base - 16'd6, "R3 negative offset", got_pc, base - 16'd6);
      base = pc;
      step({4'hE, 8'h7F, 1'b0, 3'd7}, 4'h0, 16'h0, 16'h0, 1'b1);
      chk(got_pc == base + 16'h7F, "R3 max positive offset", got_pc, base + 16'h7F);
      base = pc;
      step({4'hE, 8'h40, 1'b0, 3'd0}, 4'h0, 16'h0, 16'h0, 1'b1);
      chk(got_pc == base + 16'h2, "R3 not taken", got_pc, base + 16'h2);
   endtask

   task automatic t_reg();
      logic [15:0] base;
      step({8'hF0, 4'h3, 1'b0, 3'd7}, 4'h0, 16'h1235, 16'h0, 1'b1);
      chk(got_pc == 16'h1234, "R4 register target bit0 cleared", got_pc, 16'h1234);
      base = pc;
      step({8'hF0, 4'h3, 1'b0, 3'd0}, 4'h0, 16'h8000, 16'h0, 1'b1);
      chk(got_pc == base + 16'h2, "R4 register not taken", got_pc, base + 16'h2);
   endtask

   task automatic t_delayed();
      logic [15:0] base;
      base = pc;
      step({4'hE, 8'h20, 1'b1, 3'd7}, 4'h0, 16'h0, 16'h0, 1'b1);
      chk(got_pc == base + 16'h2, "R5 delayed goes to slot", got_pc, base + 16'h2);
      step(PLAIN, 4'h0, 16'h0, 16'h0, 1'b0);
      chk(got_pc == base + 16'h2, "R11 stall holds slot pc", got_pc, base + 16'h2);
      chk(got_we == 1'b0, "R11 no link while stalled", 16'(got_we), 16'h0);
      step(PLAIN, 4'h0, 16'h0, 16'h0, 1'b1);
      chk(got_pc == base + 16'h20, "R5 target after slot", got_pc, base + 16'h20);
      base = pc;
      step({4'hE, 8'h20, 1'b1, 3'd0}, 4'h0, 16'h0, 16'h0, 1'b1);
      step(PLAIN, 4'h0, 16'h0, 16'h0, 1'b1);
      chk(got_pc == base + 16'h4, "R5 not-taken delayed leaves nothing", got_pc, base + 16'h4);
      step({8'hF1, 4'h2, 1'b0, 3'd7}, 4'h0, 16'h4001, 16'h0, 1'b1);
      step(PLAIN, 4'h0, 16'h0, 16'h0, 1'b1);
      chk(got_pc == 16'h4000, "R5 delayed register target", got_pc, 16'h4000);
   endtask

   task automatic t_slot();
      logic [15:0] base;
      base = pc;
      step({4'hE, 8'h40, 1'b1, 3'd7}, 4'h0, 16'h0, 16'h0, 1'b1);
      step({5'b11111, 11'h005}, 4'h0, 16'h0, 16'h0, 1'b1);
      chk(got_we == 1'b0, "R6 call in slot writes no link", 16'(got_we), 16'h0);
      chk(got_pc == base + 16'h40, "R6 call in slot ignored", got_pc, base + 16'h40);
      base = pc;
      step({4'hE, 8'h10, 1'b1, 3'd7}, 4'h0, 16'h0, 16'h0, 1'b1);
      step(16'hF400, 4'h0, 16'h0, 16'h7770, 1'b1);
      chk(got_pc == base + 16'h10, "R6 return in slot ignored", got_pc, base + 16'h10);
      base = pc;
      step({4'hE, 8'h10, 1'b1, 3'd7}, 4'h0, 16'h0, 16'h0, 1'b1);
      step({4'hE, 8'h30, 1'b1, 3'd7}, 4'h0, 16'h0, 16'h0, 1'b1);
      step(PLAIN, 4'h0, 16'h0, 16'h0, 1'b1);
      chk(got_pc == base + 16'h12, "R6 delayed branch in slot leaves nothing",
          got_pc, base + 16'h12);
   endtask

   task automatic t_calls();
      logic [15:0] base;
      base = pc;
      step({5'b11111, 11'h7F0}, 4'h0, 16'h0, 16'h0, 1'b1);
      chk(got_we == 1'b1, "R7 long call link enable", 16'(got_we), 16'h1);
      chk(got_wd == base + 16'h2, "R7 long call link data", got_wd, base + 16'h2);
      chk(got_pc == base - 16'd16, "R7 long call target", got_pc, base - 16'd16);
      base = pc;
      step({5'b11111, 11'h100}, 4'h0, 16'h0, 16'h0, 1'b1);
      chk(got_pc == base + 16'h100, "R7 long call positive", got_pc, base + 16'h100);
      base = pc;
      step({8'hF5, 8'h10}, 4'h0, 16'h0, 16'h0, 1'b1);
      chk(got_we == 1'b1 && got_wd == base + 16'h2, "R8 delayed call link", got_wd, base + 16'h2);
      chk(got_pc == base + 16'h2, "R8 delayed call slot", got_pc, base + 16'h2);
      step(PLAIN, 4'h0, 16'h0, 16'h0, 1'b1);
      chk(got_pc == base + 16'h10, "R8 delayed call target", got_pc, base + 16'h10);
      base = pc;
      step({8'hF6, 4'h5, 4'h0}, 4'h0, 16'h2223, 16'h0, 1'b1);
      chk(got_we == 1'b1 && got_wd == base + 16'h2, "R9 register call link", got_wd, base + 16'h2);
      chk(got_pc == 16'h2222, "R9 register call target", got_pc, 16'h2222);
      base = pc;
      step({8'hF6, 4'h5, 1'b1, 3'd1}, 4'h4, 16'h3000, 16'h0, 1'b1);
      chk(got_we == 1'b0, "R9 conditional call not taken no link", 16'(got_we), 16'h0);
      chk(got_pc == base + 16'h2, "R9 conditional call not taken", got_pc, base + 16'h2);
      step({8'hF6, 4'h5, 1'b1, 3'd1}, 4'h0, 16'h3000, 16'h0, 1'b1);
      chk(got_we == 1'b1, "R9 conditional call taken link", 16'(got_we), 16'h1);
      chk(got_pc == 16'h3000, "R9 conditional call taken", got_pc, 16'h3000);
      step(16'hF400, 4'h0, 16'h0, 16'h3456, 1'b1);
      chk(got_pc == 16'h3456, "R10 return to link", got_pc, 16'h3456);
      chk(got_we == 1'b0, "R10 return writes no link", 16'(got_we), 16'h0);
   endtask

   task automatic t_other();
      logic [15:0] base;
      logic [15:0] list [4] = '{16'hC012, 16'hF7AB, {8'hF0, 4'h1, 1'b1, 3'd7}, 16'hF401};
      foreach (list[k]) begin
         base = pc;
         step(list[k], 4'hF, 16'h5000, 16'h6000, 1'b1);
         chk(got_pc == base + 16'h2, $sformatf("R12 other %h pc", list[k]), got_pc, base + 16'h2);
         chk(got_we == 1'b0, "R12 other no link", 16'(got_we), 16'h0);
      end
      base = pc;
      step({5'b11111, 11'h100}, 4'h0, 16'h0, 16'h0, 1'b0);
      chk(got_pc == base, "R11 invalid call holds pc", got_pc, base);
      chk(got_we == 1'b0, "R11 invalid call no link", 16'(got_we), 16'h0);
   endtask

   initial begin
      t_reset();
      t_cond();
      t_rel();
      t_reg();
      t_delayed();
      t_slot();
      t_calls();
      t_other();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", pc, pc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule